// File: doc/BRIEF.md
# DMA Activation Request Conditioner

This block turns raw activation sources into clean per-channel request signals for a small multi-channel DMA transfer engine. Each channel picks either its own active-low external request pin or one of several internal peripheral interrupt lines. It then detects that source by edge or by level, as its configuration bits choose. The result is a registered request output per channel. In the edge modes the output is a one-cycle pulse. In the level modes it is a level that follows the source.

A source that is already asserted when a channel is switched on counts as a first request in every mode. An external pin that went low before the enable was written is therefore not lost, and neither is an interrupt raised before that point. After that first acceptance, the edge modes react only to fresh transitions.

The block also holds the module-stop bit, which freezes all request logic as a clock gate would. A guard refuses to set this bit while any channel is enabled.

Top module: `dmarq_top`

## Requirements
- R1: After reset, every `dreq_o` bit is 0 and `stop_o` is 0.
- R2: With the external pin selected (`use_int_i`=0) in falling-edge mode (`ext_lvl_i`=0), a pin that is already low when `en_i` rises gives a one-cycle `dreq_o` pulse on the first clock edge after the enable.
- R3: In external falling-edge mode, a pin that stays low gives no further pulses. A later high-to-low transition of the pin gives exactly one one-cycle pulse.
- R4: In external low-level mode (`ext_lvl_i`=1), `dreq_o` stays 1 for as long as the channel is enabled and the synchronized pin is low.
- R5: The external pin passes through two synchronizer flops, so a pin change shows up at `dreq_o` on the third rising clock edge after it.
- R6: With an internal line selected in edge mode (`int_lvl_i`=0), a rising edge on that line gives a one-cycle pulse. A line that stays high gives no further pulse.
- R7: An internal line that is already high when `en_i` rises gives a one-cycle pulse on the first edge after the enable.
- R8: In internal level mode (`int_lvl_i`=1), `dreq_o` follows the selected line one clock later while the channel is enabled.
- R9: While the block is not stopped, a channel with `en_i` at 0 shows `dreq_o` at 0 after the next clock edge.
- R10: A write of 1 to the stop bit is ignored while any `en_i` bit is 1. A write of 1 with all enables at 0 sets `stop_o`. A write of 0 always clears `stop_o`.
- R11: While `stop_o` is 1, all request logic holds its state, so `dreq_o` does not change whatever the pins, lines and enables do. The logic resumes once `stop_o` returns to 0.
- R12: Channel c takes its internal line from the index `irq_sel_i[c*IW +: IW]`. Interrupt lines other than the selected one have no effect on `dreq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Request-logic clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n_i | input | NCH | External request pins, active low, asynchronous |
| irq_i | input | NIRQ | Internal peripheral interrupt lines, active high |
| en_i | input | NCH | Per-channel enable |
| ext_lvl_i | input | NCH | External sense: 0 falling edge, 1 low level |
| int_lvl_i | input | NCH | Internal sense: 0 rising edge, 1 level |
| use_int_i | input | NCH | Source: 0 external pin, 1 internal line |
| irq_sel_i | input | NCH*IW | Per-channel internal line index |
| stop_we_i | input | 1 | Stop bit write strobe |
| stop_wd_i | input | 1 | Stop bit write data |
| stop_o | output | 1 | Module-stop bit |
| dreq_o | output | NCH | Conditioned request per channel |

## Verification
The bench builds the block with two channels and four interrupt lines (IW of 2). Two channels are enough to run one channel on the external pin and the other on an internal line, and to show that the stop guard sees an enable on any channel. Four lines let the selection table place the asserted line both on and off each channel's index, at the lowest and highest positions.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    typedef struct packed {
        logic en;
        logic ext_lvl;
        logic int_lvl;
        logic use_int;
    } chan_cfg_t;

    typedef struct packed {
        logic act_prev;
        logic en_prev;
        logic req;
    } chan_state_t;

    // Next request value from config, current active level and stored state.
    function automatic logic next_req(chan_cfg_t cfg, logic active, chan_state_t st);
        logic lvl_mode;
        lvl_mode = cfg.use_int ? cfg.int_lvl : cfg.ext_lvl;
        if (!cfg.en)
            return 1'b0;
        else if (lvl_mode)
            return active;
        else if (!st.en_prev)
            return active;              // level accepted at start of acceptance
        else
            return active & ~st.act_prev;
    endfunction

endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            q      <= '1;
        end else if (ce) begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmarq_chan.sv
module dmarq_chan
    import dmarq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ce,
    input  chan_cfg_t cfg,
    input  logic      ext_act,
    input  logic      irq_bit,
    output logic      req_o
);
    chan_state_t st;
    logic        active;

    assign active = cfg.use_int ? irq_bit : ext_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (ce) begin
            st.req      <= next_req(cfg, active, st);
            st.act_prev <= active;
            st.en_prev  <= cfg.en;
        end
    end

    assign req_o = st.req;
endmodule

// File: rtl/dmarq_stop.sv
module dmarq_stop (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic wd,
    input  logic any_en,
    output logic stop_o
);
    always_ff @(posedge clk) begin
        if (rst)
            stop_o <= 1'b0;
        else if (we && !(wd && any_en))
            stop_o <= wd;
    end
endmodule

// File: rtl/dmarq_top.sv
module dmarq_top
    import dmarq_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int NIRQ = 4,
    localparam int IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    req_n_i,
    input  logic [NIRQ-1:0]   irq_i,
    input  logic [NCH-1:0]    en_i,
    input  logic [NCH-1:0]    ext_lvl_i,
    input  logic [NCH-1:0]    int_lvl_i,
    input  logic [NCH-1:0]    use_int_i,
    input  logic [NCH*IW-1:0] irq_sel_i,
    input  logic              stop_we_i,
    input  logic              stop_wd_i,
    output logic              stop_o,
    output logic [NCH-1:0]    dreq_o
);
    logic           run;
    logic [NCH-1:0] pin_sync;

    assign run = ~stop_o;

    dmarq_stop u_stop (
        .clk    (clk),
        .rst    (rst),
        .we     (stop_we_i),
        .wd     (stop_wd_i),
        .any_en (|en_i),
        .stop_o (stop_o)
    );

    dmarq_sync #(.W(NCH)) u_sync (
        .clk (clk),
        .rst (rst),
        .ce  (run),
        .d   (req_n_i),
        .q   (pin_sync)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t cfg;
        logic      irq_bit;

        assign cfg.en      = en_i[c];
        assign cfg.ext_lvl = ext_lvl_i[c];
        assign cfg.int_lvl = int_lvl_i[c];
        assign cfg.use_int = use_int_i[c];
        assign irq_bit     = irq_i[irq_sel_i[c*IW +: IW]];

        dmarq_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .ce      (run),
            .cfg     (cfg),
            .ext_act (~pin_sync[c]),
            .irq_bit (irq_bit),
            .req_o   (dreq_o[c])
        );
    end
endmodule

// File: rtl/dmarq_chk.sv
module dmarq_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] en_i,
    input logic [NCH-1:0] ext_lvl_i,
    input logic [NCH-1:0] use_int_i,
    input logic           stop_we_i,
    input logic           stop_wd_i,
    input logic           stop_o,
    input logic [NCH-1:0] dreq_o
);
    // R10: setting stop is refused while a channel is enabled
    p_stop_guard_r10: assert property (@(posedge clk) disable iff (rst)
        (stop_we_i && stop_wd_i && (|en_i) && !stop_o) |=> !stop_o);

    // R11: request outputs frozen during stop
    p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> $stable(dreq_o));

    for (genvar c = 0; c < NCH; c++) begin : g_a
        // R9: a disabled channel drops its request
        p_dis_drop_r9: assert property (@(posedge clk) disable iff (rst)
            (!stop_o && !en_i[c]) |=> !dreq_o[c]);

        // R3: external edge-mode request lasts one cycle
        p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
            (!stop_o && dreq_o[c] && !use_int_i[c] && !ext_lvl_i[c])
            |=> (!dreq_o[c] || use_int_i[c] || ext_lvl_i[c]));
    end
endmodule

bind dmarq_top dmarq_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .ext_lvl_i (ext_lvl_i),
    .use_int_i (use_int_i),
    .stop_we_i (stop_we_i),
    .stop_wd_i (stop_wd_i),
    .stop_o    (stop_o),
    .dreq_o    (dreq_o)
);

// File: tb/test_dmarq_top.sv
`timescale 1ns/1ps
module test_dmarq_top;
    localparam int NCH = 2;
    localparam int NIRQ = 4;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    req_n_i = '1;
    logic [NIRQ-1:0]   irq_i = '0;
    logic [NCH-1:0]    en_i = '0;
    logic [NCH-1:0]    ext_lvl_i = '0;
    logic [NCH-1:0]    int_lvl_i = '0;
    logic [NCH-1:0]    use_int_i = '0;
    logic [NCH*IW-1:0] irq_sel_i = '0;
    logic              stop_we_i = 1'b0;
    logic              stop_wd_i = 1'b0;
    logic              stop_o;
    logic [NCH-1:0]    dreq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dmarq_top #(.NCH(NCH), .NIRQ(NIRQ)) i_dmarq_top (
        .clk(clk), .rst(rst), .req_n_i(req_n_i), .irq_i(irq_i), .en_i(en_i),
        .ext_lvl_i(ext_lvl_i), .int_lvl_i(int_lvl_i), .use_int_i(use_int_i),
        .irq_sel_i(irq_sel_i), .stop_we_i(stop_we_i), .stop_wd_i(stop_wd_i),
        .stop_o(stop_o), .dreq_o(dreq_o)
    );

    // {irq lines, channel 0 index, expected dreq_o[0]}
    localparam logic [6:0] VEC [6] = '{
        {4'b0100, 2'd2, 1'b1},
        {4'b0100, 2'd1, 1'b0},
        {4'b1000, 2'd3, 1'b1},
        {4'b0111, 2'd3, 1'b0},
        {4'b0001, 2'd0, 1'b1},
        {4'b1110, 2'd0, 1'b0}
    };

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic stop_write(input logic v);
        stop_we_i = 1'b1;
        stop_wd_i = v;
        tick();
        stop_we_i = 1'b0;
        stop_wd_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        chk("R1 dreq", dreq_o[0] | dreq_o[1], 1'b0);
        chk("R1 stop", stop_o, 1'b0);

        // Channel 0, external pin, falling-edge mode
        req_n_i[0] = 1'b0;
        tick(3);
        chk("R9 disabled", dreq_o[0], 1'b0);
        en_i[0] = 1'b1;
        tick();
        chk("R2 pre-low accepted", dreq_o[0], 1'b1);
        tick();
        chk("R3 pulse ends", dreq_o[0], 1'b0);
        tick(3);
        chk("R3 steady low no repeat", dreq_o[0], 1'b0);
        req_n_i[0] = 1'b1;
        tick(3);
        req_n_i[0] = 1'b0;
        tick(2);
        chk("R5 not yet through sync", dreq_o[0], 1'b0);
        tick();
        chk("R3 falling edge pulse", dreq_o[0], 1'b1);
        tick();
        chk("R3 falling edge single", dreq_o[0], 1'b0);

        // Low-level mode
        ext_lvl_i[0] = 1'b1;
        tick();
        chk("R4 level asserted", dreq_o[0], 1'b1);
        tick(3);
        chk("R4 level held", dreq_o[0], 1'b1);
        req_n_i[0] = 1'b1;
        tick(2);
        chk("R5 release latency", dreq_o[0], 1'b1);
        tick();
        chk("R4 level released", dreq_o[0], 1'b0);
        req_n_i[0] = 1'b0;
        tick(3);
        chk("R4 level again", dreq_o[0], 1'b1);
        en_i[0] = 1'b0;
        tick();
        chk("R9 disable drops", dreq_o[0], 1'b0);
        ext_lvl_i[0] = 1'b0;
        req_n_i[0] = 1'b1;

        // Channel 1, internal line 2, rising-edge mode
        use_int_i[1] = 1'b1;
        irq_sel_i = 4'b1000;
        irq_i = 4'b0100;
        tick();
        en_i[1] = 1'b1;
        tick();
        chk("R7 pre-high accepted", dreq_o[1], 1'b1);
        tick();
        chk("R6 steady high no repeat", dreq_o[1], 1'b0);
        irq_i = 4'b0000;
        tick();
        chk("R6 low", dreq_o[1], 1'b0);
        irq_i = 4'b0100;
        tick();
        chk("R6 rising edge pulse", dreq_o[1], 1'b1);
        tick();
        chk("R6 single pulse", dreq_o[1], 1'b0);
        irq_i = 4'b0010;
        tick();
        chk("R12 other line ignored", dreq_o[1], 1'b0);
        irq_i = 4'b0000;
        en_i[1] = 1'b0;
        tick();

        // Channel 0, internal level mode, selection table
        use_int_i[0] = 1'b1;
        int_lvl_i[0] = 1'b1;
        en_i[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            irq_i = VEC[k][6:3];
            irq_sel_i[1:0] = VEC[k][2:1];
            tick();
            chk("R8 R12 table", dreq_o[0], VEC[k][0]);
        end
        en_i[0] = 1'b0;
        use_int_i[0] = 1'b0;
        int_lvl_i[0] = 1'b0;
        irq_i = '0;
        tick();

        // Stop guard
        en_i[0] = 1'b1;
        stop_write(1'b1);
        chk("R10 refused while enabled", stop_o, 1'b0);
        en_i[0] = 1'b0;
        tick();
        stop_write(1'b1);
        chk("R10 accepted when idle", stop_o, 1'b1);

        // Frozen while stopped
        ext_lvl_i[0] = 1'b1;
        en_i[0] = 1'b1;
        req_n_i[0] = 1'b0;
        tick(4);
        chk("R11 frozen output", dreq_o[0], 1'b0);
        stop_write(1'b0);
        chk("R10 R11 clear stop", stop_o, 1'b0);
        tick(2);
        chk("R11 resume sync", dreq_o[0], 1'b0);
        tick();
        chk("R11 resumed", dreq_o[0], 1'b1);
        en_i[0] = 1'b0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule